// File: doc/BRIEF.md
# Full-Map Coherence Directory Controller

This block is the home node for a range of memory blocks shared by a set of private caches. For every block it keeps one presence bit per cache and an exclusive bit, together with the block's memory word. Caches send it read requests, requests for exclusive ownership, and upgrade requests. The controller answers each request with a data grant. When other caches must first give up or downgrade their copy, it sends them invalidation or downgrade messages and collects their replies before it grants.

Only one transaction is in flight at a time. While it waits for replies, the affected entry is marked busy. A new request to that entry is refused with a negative acknowledgement, and the requester has to retry later. A request to any other block is held back until the transaction completes. A reply from an owner that held the block exclusively carries the latest data, which is written into the block's memory word before the grant is sent.

Top module: `dir_ctrl`

## Requirements
- R1: During reset and in the first cycle after reset, `msg_valid` is low and `req_ready` is high.
- R2: After reset, block b holds the memory word (b*37+5) mod 2^DATA_W. A Read (req_kind 0) to a block that no other cache holds is answered with an exclusive data grant (msg_kind 1) that carries that word. The requester is then recorded as the exclusive holder.
- R3: A Read to a block held in shared state by other caches is answered with a shared data grant (msg_kind 0) that carries the memory word. The requester is added to the holders.
- R4: A Read to a block held exclusively by another cache sends a downgrade (msg_kind 5) to that owner. When the owner replies with a revision (rsp_kind 1), its data is stored and returned to the requester in a shared grant. The former owner stays a holder.
- R5: A ReadEx (req_kind 1) sends an invalidation (msg_kind 4) to every holder other than the requester, one per cycle in ascending cache index. Once all of them have replied, it sends an exclusive data grant. If no other cache holds the block, the grant is sent at once.
- R6: An Upgrade (req_kind 2) from a cache that is a holder is answered with an upgrade acknowledgement (msg_kind 2) with zero data, after the other holders are invalidated. An Upgrade from a non-holder is answered like a ReadEx, with an exclusive data grant.
- R7: A request to the block whose transaction is waiting for replies is accepted and refused with a NACK (msg_kind 3, zero data) to its sender. The refused request does not change the entry.
- R8: While invalidations or a downgrade are being issued, `req_ready` is low. While replies are awaited, a request to any other block is not accepted.
- R9: After a ReadEx or Upgrade completes, the requester is the only holder and holds the block exclusively.
- R10: A reply from a cache that owes none, or a reply for a different block, is ignored and does not advance the transaction.
- R11: A grant given without invalidation appears one cycle after the request is accepted. The first invalidation or downgrade appears two cycles after acceptance, and each further one a cycle later. A grant that follows replies appears two cycles after the last owed reply is accepted. A NACK appears one cycle after its request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 2 | 0 Read, 1 ReadEx, 2 Upgrade |
| req_src | input | CW | Requesting cache index |
| req_blk | input | BW | Requested block index |
| msg_valid | output | 1 | Outgoing message present (always taken) |
| msg_kind | output | 3 | 0 shared data, 1 exclusive data, 2 upgrade ack, 3 NACK, 4 invalidate, 5 downgrade |
| msg_dst | output | CW | Destination cache index |
| msg_blk | output | BW | Block the message concerns |
| msg_data | output | DATA_W | Block data for data grants, zero otherwise |
| rsp_valid | input | 1 | Reply from a cache present |
| rsp_kind | input | 1 | 0 acknowledgement, 1 revision with data |
| rsp_src | input | CW | Replying cache index |
| rsp_blk | input | BW | Block the reply concerns |
| rsp_data | input | DATA_W | Revised data carried by a revision |

## Verification
Each expected message carries the exact cycle in which it must appear, derived from R11. A direct grant or a NACK is due one cycle after acceptance. Invalidations are due from two cycles after acceptance, one per cycle. A grant after replies is due two cycles after the last owed reply. The bench counts clock edges and compares the outgoing channel on every falling edge against a queue of these timed expectations. A message that is early, late or spurious is therefore reported. Stray replies and held requests are placed so that any wrongful effect would move a grant earlier or produce a message where none is due.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        RQ_READ    = 2'd0,
        RQ_READEX  = 2'd1,
        RQ_UPGRADE = 2'd2
    } dreq_e;

    typedef enum logic [2:0] {
        MS_SHARED_DATA = 3'd0,
        MS_EXCL_DATA   = 3'd1,
        MS_UPG_ACK     = 3'd2,
        MS_NACK        = 3'd3,
        MS_INVAL       = 3'd4,
        MS_DOWNGRADE   = 3'd5
    } dmsg_e;

    typedef enum logic {
        RS_ACK      = 1'b0,
        RS_REVISION = 1'b1
    } drsp_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_GRANT
    } dstate_e;

    // Memory word a block holds after reset.
    function automatic int unsigned reset_word(int unsigned idx);
        return idx * 37 + 5;
    endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store import dir_pkg::*; #(
    parameter int NUM_CACHES = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(NUM_BLOCKS)-1:0] rd_blk,
    output logic [NUM_CACHES-1:0]         rd_pres,
    output logic                          rd_excl,
    output logic [DATA_W-1:0]             rd_data,
    input  logic [$clog2(NUM_BLOCKS)-1:0] chk_blk,
    output logic                          chk_busy,
    input  logic                          ent_we,
    input  logic [NUM_CACHES-1:0]         ent_pres,
    input  logic                          ent_excl,
    input  logic                          busy_set,
    input  logic                          busy_clr,
    input  logic                          mem_we,
    input  logic [$clog2(NUM_BLOCKS)-1:0] mem_blk,
    input  logic [DATA_W-1:0]             mem_wdata,
    output logic [NUM_BLOCKS-1:0]         busy_vec
);
    localparam int BW = $clog2(NUM_BLOCKS);

    logic [NUM_CACHES-1:0] pres_q [NUM_BLOCKS];
    logic [NUM_BLOCKS-1:0] excl_q;
    logic [NUM_BLOCKS-1:0] busy_q;
    logic [DATA_W-1:0]     mem_q  [NUM_BLOCKS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (rst) begin
                pres_q[i] <= '0;
                excl_q[i] <= 1'b0;
                busy_q[i] <= 1'b0;
                mem_q[i]  <= DATA_W'(reset_word(i));
            end else begin
                if (ent_we && rd_blk == BW'(i)) begin
                    pres_q[i] <= ent_pres;
                    excl_q[i] <= ent_excl;
                end
                if (busy_set && rd_blk == BW'(i)) begin
                    busy_q[i] <= 1'b1;
                end else if (busy_clr && rd_blk == BW'(i)) begin
                    busy_q[i] <= 1'b0;
                end
                if (mem_we && mem_blk == BW'(i)) begin
                    mem_q[i] <= mem_wdata;
                end
            end
        end
    end

    assign rd_pres  = pres_q[rd_blk];
    assign rd_excl  = excl_q[rd_blk];
    assign rd_data  = mem_q[rd_blk];
    assign chk_busy = busy_q[chk_blk];
    assign busy_vec = busy_q;

endmodule

// File: rtl/dir_inv_picker.sv
module dir_inv_picker #(
    parameter int NUM_CACHES = 4
) (
    input  logic [NUM_CACHES-1:0]         mask,
    output logic [$clog2(NUM_CACHES)-1:0] pick_idx,
    output logic [NUM_CACHES-1:0]         rest_mask
);
    localparam int CW = $clog2(NUM_CACHES);

    logic [NUM_CACHES-1:0] below;
    logic [NUM_CACHES-1:0] onehot;

    assign below[0] = 1'b0;

    for (genvar g = 0; g < NUM_CACHES; g++) begin : g_scan
        assign onehot[g] = mask[g] & ~below[g];
        if (g < NUM_CACHES - 1) begin : g_carry
            assign below[g+1] = below[g] | mask[g];
        end
    end

    always_comb begin
        pick_idx = '0;
        for (int i = 0; i < NUM_CACHES; i++) begin
            if (onehot[i]) pick_idx = pick_idx | CW'(i);
        end
    end

    assign rest_mask = mask & ~onehot;

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl import dir_pkg::*; #(
    parameter int NUM_CACHES = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [1:0]                    req_kind,
    input  logic [$clog2(NUM_CACHES)-1:0] req_src,
    input  logic [$clog2(NUM_BLOCKS)-1:0] req_blk,
    output logic                          msg_valid,
    output logic [2:0]                    msg_kind,
    output logic [$clog2(NUM_CACHES)-1:0] msg_dst,
    output logic [$clog2(NUM_BLOCKS)-1:0] msg_blk,
    output logic [DATA_W-1:0]             msg_data,
    input  logic                          rsp_valid,
    input  logic                          rsp_kind,
    input  logic [$clog2(NUM_CACHES)-1:0] rsp_src,
    input  logic [$clog2(NUM_BLOCKS)-1:0] rsp_blk,
    input  logic [DATA_W-1:0]             rsp_data
);
    localparam int CW = $clog2(NUM_CACHES);
    localparam int BW = $clog2(NUM_BLOCKS);

    dstate_e               state;
    dreq_e                 cur_kind;
    dmsg_e                 cur_gkind;
    logic                  cur_dgrade;
    logic [CW-1:0]         cur_src;
    logic [BW-1:0]         cur_blk;
    logic [NUM_CACHES-1:0] send_mask;
    logic [NUM_CACHES-1:0] owe_mask;

    logic [BW-1:0]         rd_blk;
    logic [NUM_CACHES-1:0] rd_pres;
    logic                  rd_excl;
    logic [DATA_W-1:0]     rd_data;
    logic                  chk_busy;
    logic [NUM_BLOCKS-1:0] busy_vec;
    logic                  sending;

    dreq_e                 rq;
    logic [NUM_CACHES-1:0] src_bit;
    logic [NUM_CACHES-1:0] others;
    logic [NUM_CACHES-1:0] targets;
    logic                  dgrade;
    dmsg_e                 gkind;
    logic                  accept;
    logic                  reply_hit;

    logic [NUM_CACHES-1:0] base_bit;
    dreq_e                 base_kind;
    dmsg_e                 base_gkind;
    logic [NUM_CACHES-1:0] fin_pres;
    logic                  fin_excl;
    logic                  ent_we;

    logic [CW-1:0]         pick_idx;
    logic [NUM_CACHES-1:0] rest_mask;

    assign sending = (state == ST_SEND);
    assign rd_blk  = (state == ST_IDLE) ? req_blk : cur_blk;

    dir_store #(
        .NUM_CACHES(NUM_CACHES),
        .NUM_BLOCKS(NUM_BLOCKS),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_blk   (rd_blk),
        .rd_pres  (rd_pres),
        .rd_excl  (rd_excl),
        .rd_data  (rd_data),
        .chk_blk  (req_blk),
        .chk_busy (chk_busy),
        .ent_we   (ent_we),
        .ent_pres (fin_pres),
        .ent_excl (fin_excl),
        .busy_set (state == ST_IDLE && accept && targets != '0),
        .busy_clr (state == ST_GRANT),
        .mem_we   (reply_hit && rsp_kind == RS_REVISION),
        .mem_blk  (cur_blk),
        .mem_wdata(rsp_data),
        .busy_vec (busy_vec)
    );

    dir_inv_picker #(
        .NUM_CACHES(NUM_CACHES)
    ) u_picker (
        .mask     (send_mask),
        .pick_idx (pick_idx),
        .rest_mask(rest_mask)
    );

    // Decode an incoming request against the entry it addresses.
    always_comb begin
        rq      = dreq_e'(req_kind);
        src_bit = NUM_CACHES'(1) << req_src;
        others  = rd_pres & ~src_bit;
        targets = '0;
        dgrade  = 1'b0;
        gkind   = MS_EXCL_DATA;
        if (rq == RQ_READEX || rq == RQ_UPGRADE) begin
            targets = others;
            gkind   = (rq == RQ_UPGRADE && rd_pres[req_src]) ? MS_UPG_ACK : MS_EXCL_DATA;
        end else if (rd_excl && others != '0) begin
            targets = others;
            dgrade  = 1'b1;
            gkind   = MS_SHARED_DATA;
        end else begin
            gkind   = (others == '0) ? MS_EXCL_DATA : MS_SHARED_DATA;
        end
    end

    always_comb begin
        case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_WAIT: req_ready = chk_busy;
            default: req_ready = 1'b0;
        endcase
    end

    assign accept    = req_valid && req_ready;
    assign reply_hit = rsp_valid && (state == ST_SEND || state == ST_WAIT) &&
                       rsp_blk == cur_blk && owe_mask[rsp_src];

    // New entry contents written when a grant is issued.
    always_comb begin
        base_bit   = (state == ST_IDLE) ? src_bit : (NUM_CACHES'(1) << cur_src);
        base_kind  = (state == ST_IDLE) ? rq : cur_kind;
        base_gkind = (state == ST_IDLE) ? gkind : cur_gkind;
        if (base_kind == RQ_READEX || base_kind == RQ_UPGRADE) begin
            fin_pres = base_bit;
            fin_excl = 1'b1;
        end else begin
            fin_pres = rd_pres | base_bit;
            fin_excl = (base_gkind == MS_EXCL_DATA);
        end
    end

    assign ent_we = (state == ST_IDLE && accept && targets == '0) || (state == ST_GRANT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_kind   <= RQ_READ;
            cur_gkind  <= MS_SHARED_DATA;
            cur_dgrade <= 1'b0;
            cur_src    <= '0;
            cur_blk    <= '0;
            send_mask  <= '0;
            owe_mask   <= '0;
            msg_valid  <= 1'b0;
            msg_kind   <= '0;
            msg_dst    <= '0;
            msg_blk    <= '0;
            msg_data   <= '0;
        end else begin
            msg_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_kind   <= rq;
                        cur_gkind  <= gkind;
                        cur_dgrade <= dgrade;
                        cur_src    <= req_src;
                        cur_blk    <= req_blk;
                        if (targets != '0) begin
                            send_mask <= targets;
                            owe_mask  <= targets;
                            state     <= ST_SEND;
                        end else begin
                            msg_valid <= 1'b1;
                            msg_kind  <= gkind;
                            msg_dst   <= req_src;
                            msg_blk   <= req_blk;
                            msg_data  <= (gkind == MS_UPG_ACK) ? '0 : rd_data;
                        end
                    end
                end
                ST_SEND: begin
                    msg_valid <= 1'b1;
                    msg_kind  <= cur_dgrade ? MS_DOWNGRADE : MS_INVAL;
                    msg_dst   <= pick_idx;
                    msg_blk   <= cur_blk;
                    msg_data  <= '0;
                    send_mask <= rest_mask;
                    if (rest_mask == '0) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (accept) begin
                        msg_valid <= 1'b1;
                        msg_kind  <= MS_NACK;
                        msg_dst   <= req_src;
                        msg_blk   <= req_blk;
                        msg_data  <= '0;
                    end
                    if (owe_mask == '0) state <= ST_GRANT;
                end
                default: begin
                    msg_valid <= 1'b1;
                    msg_kind  <= cur_gkind;
                    msg_dst   <= cur_src;
                    msg_blk   <= cur_blk;
                    msg_data  <= (cur_gkind == MS_UPG_ACK) ? '0 : rd_data;
                    state     <= ST_IDLE;
                end
            endcase
            if (reply_hit) begin
                owe_mask <= owe_mask & ~(NUM_CACHES'(1) << rsp_src);
            end
        end
    end

endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk import dir_pkg::*; #(
    parameter int NUM_CACHES = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W     = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic                          msg_valid,
    input logic [2:0]                    msg_kind,
    input logic [$clog2(NUM_CACHES)-1:0] msg_dst,
    input logic [DATA_W-1:0]             msg_data,
    input logic [NUM_BLOCKS-1:0]         busy_vec,
    input logic                          sending
);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !$past(rst)); // R1

    AST_NACK_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_NACK) |-> $past(req_valid && req_ready)); // R7

    AST_NODATA_KINDS: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind >= 3'd2) |-> msg_data == '0); // R6

    AST_SINGLE_BUSY: assert property (@(posedge clk) disable iff (rst)
        $countones(busy_vec) <= 1); // R8

    AST_NO_ACCEPT_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst)
        sending |-> !req_ready); // R8

    AST_INVAL_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_INVAL && $past(msg_valid && msg_kind == MS_INVAL))
        |-> msg_dst > $past(msg_dst)); // R5

endmodule

bind dir_ctrl dir_ctrl_chk #(
    .NUM_CACHES(NUM_CACHES),
    .NUM_BLOCKS(NUM_BLOCKS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .msg_valid(msg_valid),
    .msg_kind (msg_kind),
    .msg_dst  (msg_dst),
    .msg_data (msg_data),
    .busy_vec (busy_vec),
    .sending  (sending)
);

// File: tb/dir_ctrl_tb.sv
module dir_ctrl_tb;
    localparam int NC = 4;
    localparam int NB = 8;
    localparam int DW = 16;
    localparam int CW = 2;
    localparam int BW = 3;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [CW-1:0] req_src = '0;
    logic [BW-1:0] req_blk = '0;
    logic          msg_valid;
    logic [2:0]    msg_kind;
    logic [CW-1:0] msg_dst;
    logic [BW-1:0] msg_blk;
    logic [DW-1:0] msg_data;
    logic          rsp_valid = 1'b0;
    logic          rsp_kind = 1'b0;
    logic [CW-1:0] rsp_src = '0;
    logic [BW-1:0] rsp_blk = '0;
    logic [DW-1:0] rsp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_ctrl #(.NUM_CACHES(NC), .NUM_BLOCKS(NB), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_blk(req_blk),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
        .msg_blk(msg_blk), .msg_data(msg_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_src(rsp_src),
        .rsp_blk(rsp_blk), .rsp_data(rsp_data)
    );

    typedef struct packed {
        logic [31:0]   due;
        logic [7:0]    tag;
        logic [2:0]    k;
        logic [CW-1:0] d;
        logic [BW-1:0] b;
        logic [DW-1:0] data;
    } exp_t;

    exp_t          exp_q [$];
    int            checks = 0;
    int            fails = 0;
    int            cyc = 0;
    bit            done = 0;
    logic [NC-1:0] m_pres [NB];
    bit            m_excl [NB];
    logic [DW-1:0] m_mem  [NB];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input int tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input int due, input int tag, input int k, input int d,
                        input int b, input logic [DW-1:0] data);
        exp_t e;
        e.due = due; e.tag = 8'(tag); e.k = 3'(k); e.d = CW'(d); e.b = BW'(b); e.data = data;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Timed comparison of the outgoing channel (R11 timing for every message).
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_q.size() > 0 && exp_q[0].due == 32'(cyc)) begin
                exp_t e;
                e = exp_q.pop_front();
                check(msg_valid && msg_kind == e.k && msg_dst == e.d &&
                      msg_blk == e.b && msg_data == e.data, int'(e.tag), "message",
                      {3'd0, msg_valid, 1'b0, msg_kind, 2'd0, msg_dst, 1'b0, msg_blk, msg_data},
                      {4'd1, 1'b0, e.k, 2'd0, e.d, 1'b0, e.b, e.data});
            end else if (msg_valid) begin
                check(0, 11, "unexpected message",
                      {13'd0, msg_kind, msg_data}, 32'hFFFF_FFFF);
            end
        end
    end

    // One request with full reply handling, driven from the bench's own model.
    task automatic run_txn(input int kind, input int src, input int blk,
                           input logic [DW-1:0] rev_data, input int tag,
                           input bit probe, input int probe_src, input int other_blk,
                           input bit stray);
        logic [NC-1:0] sb;
        logic [NC-1:0] others;
        logic [NC-1:0] targets;
        bit            dg;
        int            gk;
        int            n;
        int            a_cyc;
        int            j;
        int            last;
        bit            is_read;
        sb      = NC'(1) << src;
        others  = m_pres[blk] & ~sb;
        is_read = (kind == 0);
        dg      = 0;
        if (is_read) begin
            if (m_excl[blk] && others != '0) begin
                targets = others; dg = 1; gk = 0;
            end else begin
                targets = '0; gk = (others == '0) ? 1 : 0;
            end
        end else begin
            targets = others;
            gk = (kind == 2 && m_pres[blk][src]) ? 2 : 1;
        end
        n = $countones(targets);

        @(negedge clk);
        req_valid = 1; req_kind = 2'(kind); req_src = CW'(src); req_blk = BW'(blk);
        #1;
        check(req_ready == 1'b1, tag, "request ready in idle", 32'(req_ready), 32'd1);
        a_cyc = cyc + 1;
        if (targets == '0) begin
            push(a_cyc, tag, gk, src, blk, (gk == 2) ? '0 : m_mem[blk]);
        end else begin
            j = 0;
            for (int i = 0; i < NC; i++) begin
                if (targets[i]) begin
                    push(a_cyc + 1 + j, tag, dg ? 5 : 4, i, blk, '0);
                    j++;
                    last = i;
                end
            end
        end
        @(posedge clk);
        #1 req_valid = 0;

        if (targets != '0) begin
            @(negedge clk);
            while (cyc < a_cyc + n) @(negedge clk);
            if (probe) begin
                // R7: request to the busy block is refused
                req_valid = 1; req_kind = 2'd0; req_src = CW'(probe_src); req_blk = BW'(blk);
                #1;
                check(req_ready == 1'b1, 7, "busy block request taken for NACK", 32'(req_ready), 32'd1);
                push(cyc + 1, 7, 3, probe_src, blk, '0);
                @(negedge clk);
                // R8: request to another block is held
                req_blk = BW'(other_blk);
                #1;
                check(req_ready == 1'b0, 8, "other block held while busy", 32'(req_ready), 32'd0);
                @(negedge clk);
                req_valid = 0;
            end
            if (stray) begin
                // R10: replies not owed must not advance the transaction
                rsp_valid = 1; rsp_kind = 1'b0; rsp_src = CW'(src); rsp_blk = BW'(blk);
                @(negedge clk);
                rsp_src = CW'(last); rsp_blk = BW'(other_blk);
                @(negedge clk);
                rsp_valid = 0;
            end
            for (int i = 0; i < NC; i++) begin
                if (targets[i]) begin
                    rsp_valid = 1; rsp_src = CW'(i); rsp_blk = BW'(blk);
                    if (dg || m_excl[blk]) begin
                        rsp_kind = 1'b1; rsp_data = rev_data; m_mem[blk] = rev_data;
                    end else begin
                        rsp_kind = 1'b0; rsp_data = '0;
                    end
                    if (i == last) push(cyc + 3, tag, gk, src, blk, (gk == 2) ? '0 : m_mem[blk]);
                    @(negedge clk);
                end
            end
            rsp_valid = 0;
        end

        if (is_read) begin
            m_pres[blk] = m_pres[blk] | sb;
            m_excl[blk] = (gk == 1);
        end else begin
            m_pres[blk] = sb;
            m_excl[blk] = 1;
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, tag, "all expected messages seen", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual=expired expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_pres[b] = '0;
            m_excl[b] = 0;
            m_mem[b]  = DW'(b * 37 + 5);
        end
        repeat (3) @(negedge clk);
        check(msg_valid == 1'b0, 1, "no message in reset", 32'(msg_valid), 32'd0); // R1
        rst = 0;
        @(negedge clk);
        check(msg_valid == 1'b0, 1, "no message after reset", 32'(msg_valid), 32'd0); // R1
        check(req_ready == 1'b1, 1, "ready after reset", 32'(req_ready), 32'd1);     // R1

        run_txn(0, 0, 1, '0, 2, 0, 0, 0, 0);         // R2: unheld read, reset word 42
        run_txn(0, 1, 1, 16'hBEEF, 4, 0, 0, 0, 0);   // R4: downgrade of exclusive owner
        run_txn(0, 2, 1, '0, 3, 0, 0, 0, 0);         // R3: shared grant
        run_txn(1, 3, 1, '0, 5, 1, 0, 5, 1);         // R5 with R7, R8, R10 probes
        run_txn(0, 0, 1, 16'h1234, 9, 0, 0, 0, 0);   // R9: only c3 owned it
        run_txn(2, 0, 1, '0, 6, 0, 0, 0, 0);         // R6: upgrade from sharer
        run_txn(0, 2, 1, 16'h5555, 9, 0, 0, 0, 0);   // R9: c0 became sole owner
        run_txn(2, 2, 2, '0, 6, 0, 0, 0, 0);         // R6: upgrade from non-holder
        run_txn(1, 2, 2, '0, 5, 0, 0, 0, 0);         // R5: requester is sole holder
        run_txn(0, 3, 6, '0, 2, 0, 0, 0, 0);         // R2: reset word 227
        run_txn(1, 1, 1, '0, 5, 0, 0, 0, 0);         // R5: invalidate c0 and c2
        run_txn(0, 1, 1, '0, 11, 0, 0, 0, 0);        // R11: owner rereads, direct grant

        finish_run();
    end

endmodule